// File: doc/BRIEF.md
# Grouped-Byte ECC Read-Modify-Write Unit

This unit sits between a byte-wide access path and a word memory in which each 38-bit word stores four consecutive bytes together with six Hamming check bits. A byte read fetches the word that holds the byte, repairs any single flipped bit and returns the selected byte along with a flag that reports a repair. A byte write never touches the memory on its own. The unit gathers bytes aimed at one group into a staging word, then reads the stored word, repairs it, merges the staged bytes over it, recomputes the check bits and writes all 38 bits back in one memory write.

Because of this, writing a single byte reprograms all four bytes of its group. Each group write-back raises a one-cycle pulse that carries the group index, so an external counter can track endurance per group. A test port can flip one chosen codeword bit as a word is written back. This stores a known single-bit error, and later reads must repair it.

The memory side has a fixed one-cycle read latency. `mem_rdata` is valid in the cycle after a read request.

Top module: `grp_ecc_rmw`

## Requirements
- R1: A read of byte address A returns byte A[1:0] of group A[GRP_W+1:2]. Byte k of a group sits in data bits 8k+7..8k.
- R2: Stored word bit i is Hamming position i+1, for positions 1 to 38. Check bits sit at positions 1, 2, 4, 8, 16 and 32, and each one is the XOR of the data positions whose index has that bit set. Data bits 0 to 31 fill the remaining positions in ascending order. Data 0x00000001 therefore encodes to 0x7.
- R3: When exactly one of the 38 stored bits is flipped, every byte of the group still reads back correct, and `rd_corr` is 1 with that read result.
- R4: A read of a clean word gives `rd_corr` = 0.
- R5: A byte write leaves the other three bytes of its group unchanged, and a single-bit error already in the stored word is repaired during the merge.
- R6: Consecutive writes to one group are staged and written back together in one memory write. The write-back starts when a write with `req_last` = 1 is accepted, or when any request arrives that is not a write to the staged group. While such a request waits, `req_ready` is 0.
- R7: Each memory write-back is followed one cycle later by exactly one `wc_pulse`, with `wc_grp` set to the group written.
- R8: If `inj_en` = 1 during a write-back, stored bit `inj_pos` is inverted relative to the correct codeword.
- R9: Reads issue no memory write and produce no `wc_pulse`. `rd_valid` rises two cycles after the memory read request.
- R10: A read of a group with staged bytes returns the newly written value.
- R11: After reset, `req_ready` = 1 while nothing is staged, and `rd_valid`, `wc_pulse` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Byte request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_last | input | 1 | Last byte of a write burst; starts the write-back |
| req_addr | input | GRP_W+2 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | 8 | Read byte |
| rd_corr | output | 1 | A single-bit error was repaired for this result |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (with mem_req) |
| mem_addr | output | GRP_W | Group index |
| mem_wdata | output | 38 | Codeword to store |
| mem_rdata | input | 38 | Stored codeword, one cycle after a read request |
| inj_en | input | 1 | Test: flip one bit of the next written codeword |
| inj_pos | input | 6 | Test: codeword bit to flip |
| wc_pulse | output | 1 | One group write cycle completed |
| wc_grp | output | GRP_W | Group that was written |

## Verification
Reads are tried on words holding a four-byte pattern in which every byte differs, so that a wrong byte-lane selection shows up as a wrong value. Two single-bit data words are written and the stored codewords are compared bit for bit, which separates a wrong bit placement from a wrong parity coverage. A flip is injected at every one of the 38 positions, and all four bytes are then read back. This tells data-bit repair apart from check-bit repair, and the injection write itself tests repair during the merge. Staging is exercised in three ways: a whole-group burst, a write to one group interrupted by a write to another group, and a write interrupted by a read. The per-group pulse counts show whether the bytes were merged into one write-back or sent one by one.

// File: rtl/grp_ecc_rmw.sv
module grp_ecc_rmw #(
  parameter int GRP_W = 6,
  localparam int AW = GRP_W + 2,
  localparam int CW = 38
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_last,
  input  logic [AW-1:0]    req_addr,
  input  logic [7:0]       req_wdata,
  output logic             req_ready,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             rd_corr,
  output logic             mem_req,
  output logic             mem_we,
  output logic [GRP_W-1:0] mem_addr,
  output logic [CW-1:0]    mem_wdata,
  input  logic [CW-1:0]    mem_rdata,
  input  logic             inj_en,
  input  logic [5:0]       inj_pos,
  output logic             wc_pulse,
  output logic [GRP_W-1:0] wc_grp
);
  localparam int DW = 32;
  localparam int PW = CW - DW;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_DEC} st_t;

  function automatic logic [CW-1:0] enc(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    int j;
    c = '0;
    j = 0;
    for (int p = 1; p <= CW; p++)
      if ((p & (p - 1)) != 0) begin
        c[p-1] = d[j];
        j++;
      end
    for (int k = 0; k < PW; k++) begin
      logic b;
      b = 1'b0;
      for (int p = 1; p <= CW; p++)
        if (p[k]) b = b ^ c[p-1];
      c[(1 << k) - 1] = b;
    end
    return c;
  endfunction

  function automatic logic [DW:0] dec(input logic [CW-1:0] cin);
    logic [CW-1:0] c;
    logic [PW-1:0] s;
    logic [DW-1:0] d;
    int j;
    c = cin;
    s = '0;
    for (int p = 1; p <= CW; p++)
      if (c[p-1]) s = s ^ PW'(p);
    if (s != '0 && int'(s) <= CW) c[int'(s) - 1] = ~c[int'(s) - 1];
    d = '0;
    j = 0;
    for (int p = 1; p <= CW; p++)
      if ((p & (p - 1)) != 0) begin
        d[j] = c[p-1];
        j++;
      end
    return {s != '0, d};
  endfunction

  st_t              state;
  logic             op_wr, pend;
  logic [GRP_W-1:0] grp;
  logic [1:0]       sel;
  logic [3:0]       pmask;
  logic [DW-1:0]    pdata, merged;
  logic [DW:0]      fixed;

  wire [GRP_W-1:0] req_grp = req_addr[AW-1:2];

  assign req_ready = (state == S_IDLE) && (!pend || (req_write && req_grp == grp));
  assign fixed     = dec(mem_rdata);

  always_comb
    for (int k = 0; k < 4; k++)
      merged[8*k +: 8] = pmask[k] ? pdata[8*k +: 8] : fixed[8*k +: 8];

  assign mem_req   = (state == S_RD) || (state == S_DEC && op_wr);
  assign mem_we    = (state == S_DEC) && op_wr;
  assign mem_addr  = grp;
  assign mem_wdata = enc(merged) ^ (inj_en ? (CW'(1) << inj_pos) : '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= S_IDLE;
      op_wr    <= 1'b0;
      pend     <= 1'b0;
      grp      <= '0;
      sel      <= '0;
      pmask    <= '0;
      pdata    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_corr  <= 1'b0;
      wc_pulse <= 1'b0;
      wc_grp   <= '0;
    end else begin
      rd_valid <= 1'b0;
      rd_corr  <= 1'b0;
      wc_pulse <= 1'b0;
      case (state)
        S_IDLE:
          if (req_valid && req_ready) begin
            grp <= req_grp;
            if (req_write) begin
              pend <= 1'b1;
              pmask[req_addr[1:0]] <= 1'b1;
              pdata[8*req_addr[1:0] +: 8] <= req_wdata;
              if (req_last) begin
                op_wr <= 1'b1;
                state <= S_RD;
              end
            end else begin
              sel   <= req_addr[1:0];
              op_wr <= 1'b0;
              state <= S_RD;
            end
          end else if (req_valid && pend) begin
            op_wr <= 1'b1;
            state <= S_RD;
          end
        S_RD: state <= S_DEC;
        default: begin
          state <= S_IDLE;
          if (op_wr) begin
            pend     <= 1'b0;
            pmask    <= '0;
            wc_pulse <= 1'b1;
            wc_grp   <= grp;
          end else begin
            rd_valid <= 1'b1;
            rd_data  <= fixed[8*sel +: 8];
            rd_corr  <= fixed[DW];
          end
        end
      endcase
    end
endmodule

module grp_ecc_rmw_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rd_valid,
  input logic rd_corr,
  input logic mem_req,
  input logic mem_we,
  input logic wc_pulse
);
  p_we_with_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);
  p_pulse_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wc_pulse |-> $past(mem_req && mem_we));
  p_read_result_timing_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(mem_req && !mem_we, 2));
  p_corr_only_on_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_corr |-> rd_valid);
  p_busy_blocks_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);
  p_no_pulse_with_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !wc_pulse);
endmodule

bind grp_ecc_rmw grp_ecc_rmw_chk u_chk (.*);

// File: tb/grp_ecc_rmw_bench.sv
module grp_ecc_rmw_bench;
  localparam int GRP_W = 6;
  localparam int NG = 1 << GRP_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_last = 1'b0;
  logic [GRP_W+1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rd_valid, rd_corr, mem_req, mem_we, wc_pulse;
  logic [7:0] rd_data;
  logic [GRP_W-1:0] mem_addr, wc_grp;
  logic [37:0] mem_wdata, mem_rdata;
  logic inj_en = 1'b0;
  logic [5:0] inj_pos = '0;

  grp_ecc_rmw #(.GRP_W(GRP_W)) u_grp_ecc_rmw (.*);

  always #4 clk = ~clk;

  logic [37:0] mem [NG];
  always @(posedge clk)
    if (!rst_n) begin
      for (int i = 0; i < NG; i++) mem[i] <= '0;
      mem_rdata <= '0;
    end else if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else mem_rdata <= mem[mem_addr];
    end

  int n_chk = 0, n_fail = 0;
  int wc_cnt [NG];
  logic [7:0] gold [4*NG];
  logic [8:0] exp_q [$];
  string tag_q [$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && wc_pulse) wc_cnt[wc_grp]++;
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R9 unexpected read result", {55'd0, rd_corr, rd_data}, 0);
      else begin
        logic [8:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({rd_corr, rd_data} == e, t, {55'd0, rd_corr, rd_data}, {55'd0, e});
      end
    end
  end

  task automatic send(input bit w, input int a, input logic [7:0] d, input bit last);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_last = last;
    req_addr = (GRP_W+2)'(a); req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (w) gold[a] = d;
  endtask

  task automatic rd(input int a, input bit corr, input string tag);
    exp_q.push_back({corr, gold[a]});
    tag_q.push_back(tag);
    send(1'b0, a, 8'h00, 1'b0);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [37:0] w0;
    int c0;
    for (int i = 0; i < NG; i++) wc_cnt[i] = 0;
    for (int i = 0; i < 4*NG; i++) gold[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rd_valid && !wc_pulse && !mem_req, "R11 reset state",
          {req_ready, rd_valid, wc_pulse, mem_req}, 4'b1000);

    // R2 encoding
    send(1'b1, 4*1 + 0, 8'h01, 1'b1); settle();
    check(mem[1] == 38'h7, "R2 data bit0 codeword", mem[1], 38'h7);
    send(1'b1, 4*1 + 0, 8'h00, 1'b0);
    send(1'b1, 4*1 + 3, 8'h80, 1'b1); settle();
    w0 = (38'd1 << 37) | (38'd1 << 31) | (38'd1 << 3) | (38'd1 << 1);
    check(mem[1] == w0, "R2 data bit31 codeword", mem[1], w0);
    check(wc_cnt[1] == 2, "R7 two write-backs group1", wc_cnt[1], 2);

    // R6 burst merge, R1 lanes
    send(1'b1, 8, 8'hD4, 1'b0); send(1'b1, 9, 8'hC3, 1'b0);
    send(1'b1, 10, 8'hB2, 1'b0); send(1'b1, 11, 8'hA1, 1'b1); settle();
    check(wc_cnt[2] == 1, "R6 burst one write-back", wc_cnt[2], 1);
    check(mem[2][37:0] != '0, "R6 group2 stored", mem[2], 1);
    for (int b = 0; b < 4; b++) rd(8 + b, 1'b0, "R1 R4 byte lane read");
    settle();
    check(wc_cnt[2] == 1, "R9 reads write nothing", wc_cnt[2], 1);

    // R5 single byte keeps neighbours
    send(1'b1, 9, 8'h5A, 1'b1); settle();
    for (int b = 0; b < 4; b++) rd(8 + b, 1'b0, "R5 neighbours kept");
    settle();

    // R6 interrupted by other group
    send(1'b1, 28, 8'h77, 1'b0);
    send(1'b1, 33, 8'h99, 1'b1); settle();
    check(wc_cnt[7] == 1 && wc_cnt[8] == 1, "R6 flush on group change",
          {wc_cnt[7][15:0], wc_cnt[8][15:0]}, 32'h00010001);
    rd(28, 1'b0, "R6 staged byte stored"); rd(33, 1'b0, "R6 second group");

    // R10 read after staged write
    send(1'b1, 14, 8'h3C, 1'b0);
    rd(14, 1'b0, "R10 read sees staged byte");
    settle();
    check(wc_cnt[3] == 1, "R10 one write-back", wc_cnt[3], 1);

    // R8 injection at ends
    send(1'b1, 20, 8'hE1, 1'b0); send(1'b1, 21, 8'h1E, 1'b0);
    send(1'b1, 22, 8'h69, 1'b0); send(1'b1, 23, 8'h96, 1'b1); settle();
    w0 = mem[5];
    inj_en = 1'b1; inj_pos = 6'd0;
    send(1'b1, 20, 8'hE1, 1'b1); settle();
    check(mem[5] == (w0 ^ 38'd1), "R8 flip bit0", mem[5], w0 ^ 38'd1);
    inj_pos = 6'd37;
    send(1'b1, 20, 8'hE1, 1'b1); settle();
    inj_en = 1'b0;
    check(mem[5] == (w0 ^ (38'd1 << 37)), "R8 flip bit37 after repair", mem[5], w0 ^ (38'd1 << 37));

    // R3 every position
    for (int p = 0; p < 38; p++) begin
      inj_en = 1'b1; inj_pos = 6'(p);
      send(1'b1, 20, 8'hE1, 1'b1); settle();
      inj_en = 1'b0;
      for (int b = 0; b < 4; b++) rd(20 + b, 1'b1, "R3 single flip repaired");
    end
    settle();

    // R5 repair during merge
    c0 = wc_cnt[5];
    send(1'b1, 22, 8'h42, 1'b1); settle();
    check(wc_cnt[5] == c0 + 1, "R7 one pulse per write-back", wc_cnt[5], c0 + 1);
    for (int b = 0; b < 4; b++) rd(20 + b, 1'b0, "R5 merge repaired and clean");
    settle(); settle();
    check(exp_q.size() == 0, "R9 all reads answered", exp_q.size(), 0);
    finish_run();
  end
endmodule